// File: doc/BRIEF.md
# Strobe-Latched Serial Configuration Interface

This block takes 8-bit configuration words over three wires: a serial clock, a data line and a strobe. Bits are shifted in while the strobe is low. A rising strobe commits the last eight bits into one of eight setting registers. The low three bits of the word choose the register. All serial wires are asynchronous to the system clock. They are brought in through two-flop synchronizers, and their edges are detected in the system clock domain.

The registers drive decoded fields that go to two stepper sequencer groups, to the bridge-control logic of four H-bridge channels, and to the digital code inputs of the voltage and current references. Most fields take effect at the commit. The stepper direction and excitation-mode bits are different: they wait in a staging register and move to the outputs on the next rising edge of that group's step clock. This lets a direction change line up with a motor step instead of landing between steps.

Top module: `ser_cfg_if`

## Requirements
- R1: A word is shifted in with bit D0 first and D7 last. Each bit is taken from the data line at a rising edge of the serial clock. In the tables below, bit Dn of a word is bit n of the byte value.
- R2: A rising edge of the strobe commits the word. The selector value D0 + 2·D1 + 4·D2 picks exactly one register, and no other register changes. Outputs take the new value on the third system-clock edge after the strobe pin rises.
- R3: Serial clock edges that occur while the strobe is high are ignored. A later strobe commits the word shifted before the strobe went high.
- R4: Selector 0 sets stepper group 0 and selector 1 sets stepper group 1. In these words D5 is hold, D6 is counter clear and D7 is output enable. All three take effect at the commit.
- R5: In a stepper word, D3 (direction) and D4 (excitation mode) are staged. They reach the outputs only on the next rising edge of that group's own step clock. A later word sent before that edge replaces the staged values.
- R6: Selector 2 sets bridge mode. D3 selects PWM input, D4 selects fast decay, and D6..D5 form the PWM allocation, with D5 as its low bit.
- R7: Selector 3 sets bridge polarity. D3 chooses the channel pair: 0 writes bridge_pol[3:0] and 1 writes bridge_pol[7:4]. The chosen nibble takes {D7,D6,D5,D4}. The other nibble is kept.
- R8: Selector 5 sets group 0 and selector 6 sets group 1. Each group's 4-bit divisor code {D6..D3} goes to vdiv_code[4g+3:4g], and D7 goes to vref_ext[g] (1 = external reference).
- R9: Selector 7 loads the current code {D6..D3}. D7 chooses the channel: 0 writes cur_code[3:0] and 1 writes cur_code[7:4].
- R10: Selector 4 sets D3 to sensor_on and {D6,D5,D4} to hyst_en[2:0]. D7 of this word is ignored.
- R11: A synchronous reset clears every output and every staged field to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, D0 first |
| ser_stb | input | 1 | Commit strobe, active on rising edge |
| step_clk | input | 2 | Step clock of each stepper group |
| step_dir | output | 2 | Applied direction per group |
| step_mode | output | 2 | Applied excitation mode per group |
| step_hold | output | 2 | Hold per group |
| step_cnt_clr | output | 2 | Position counter clear per group |
| step_out_en | output | 2 | Output enable per group |
| pwm_sel | output | 1 | Group 1 input used as PWM instead of a step clock |
| decay_fast | output | 1 | Fast decay selected |
| pwm_alloc | output | 2 | PWM channel allocation |
| bridge_pol | output | 8 | Drive polarity, 2 bits per bridge channel |
| vdiv_code | output | 8 | Voltage divisor code, 4 bits per group |
| vref_ext | output | 2 | External reference select per group |
| cur_code | output | 8 | Current reference code, 4 bits per channel |
| sensor_on | output | 1 | Photosensor drive on |
| hyst_en | output | 3 | Hysteresis enable per input buffer |

## Verification
The assertions check three rules on every cycle:
- at most one register is written per commit;
- a commit lasts exactly one cycle;
- the shift register does not move while the strobe is high.

They also check that a group's applied direction and mode change only after that group's step clock edge, and that the divisor fields change only after a commit to their own selector.

Other behaviour can only be shown by the bench's scenarios:
- the field decoding of each word type;
- the exact three-cycle commit latency;
- replacement of staged values by a later word;
- the fact that one group's step clock does not release the other group's staged fields.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam int FRAME_W  = 8;
    localparam int SEL_W    = 3;
    localparam int N_SEL    = 1 << SEL_W;
    localparam int STEP_GRP = 2;
    localparam int CODE_W   = 4;
    localparam int HYST_N   = 3;
    localparam int POL_W    = 2;
    localparam int POL_CH   = 4;
    localparam int NIB_W    = 2 * POL_W;

    localparam int SEL_STEP0  = 0;
    localparam int SEL_BRIDGE = 2;
    localparam int SEL_POL    = 3;
    localparam int SEL_MISC   = 4;
    localparam int SEL_VDIV0  = 5;
    localparam int SEL_CUR    = 7;

    typedef struct packed {
        logic [STEP_GRP-1:0]        dir;
        logic [STEP_GRP-1:0]        mode;
        logic [STEP_GRP-1:0]        dir_pend;
        logic [STEP_GRP-1:0]        mode_pend;
        logic [STEP_GRP-1:0]        hold;
        logic [STEP_GRP-1:0]        cnt_clr;
        logic [STEP_GRP-1:0]        out_en;
        logic                       pwm_sel;
        logic                       decay_fast;
        logic [1:0]                 pwm_alloc;
        logic [POL_CH*POL_W-1:0]    pol;
        logic [STEP_GRP*CODE_W-1:0] vdiv;
        logic [STEP_GRP-1:0]        vref_ext;
        logic [2*CODE_W-1:0]        cur;
        logic                       sensor;
        logic [HYST_N-1:0]          hyst;
    } cfg_state_t;

    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic               sclk_prev;
        logic               stb_prev;
    } shift_state_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift
    import cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk_s,
    input  logic               sdat_s,
    input  logic               stb_s,
    output logic [FRAME_W-1:0] frame,
    output logic               commit
);
    shift_state_t st_d, st_q;
    logic sclk_rise;

    assign sclk_rise = sclk_s & ~st_q.sclk_prev;
    assign commit    = stb_s & ~st_q.stb_prev;
    assign frame     = st_q.shreg;

    always_comb begin
        st_d = st_q;
        st_d.sclk_prev = sclk_s;
        st_d.stb_prev  = stb_s;
        // New bit enters at the top, so D0 ends up in bit 0 after eight shifts
        if (sclk_rise && !stb_s) begin
            st_d.shreg = {sdat_s, st_q.shreg[FRAME_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R3: strobe high freezes the shifter
    a_r3_freeze_on_strobe: assert property (@(posedge clk) disable iff (rst)
        stb_s |=> $stable(st_q.shreg));

    // R2: a strobe edge gives a single commit pulse
    a_r2_commit_single: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
    import cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                commit,
    input  logic [FRAME_W-1:0]  frame,
    input  logic [STEP_GRP-1:0] step_rise,
    output cfg_state_t          cfg
);
    cfg_state_t        st_d, st_q;
    logic [N_SEL-1:0]  wr_en;
    logic [SEL_W-1:0]  sel;

    assign sel = frame[SEL_W-1:0];

    always_comb begin
        wr_en = '0;
        if (commit) wr_en[sel] = 1'b1;
    end

    always_comb begin
        st_d = st_q;
        for (int g = 0; g < STEP_GRP; g++) begin
            // Staged fields released by this group's own step edge
            if (step_rise[g]) begin
                st_d.dir[g]  = st_q.dir_pend[g];
                st_d.mode[g] = st_q.mode_pend[g];
            end
            if (wr_en[SEL_STEP0 + g]) begin
                st_d.dir_pend[g]  = frame[3];
                st_d.mode_pend[g] = frame[4];
                st_d.hold[g]      = frame[5];
                st_d.cnt_clr[g]   = frame[6];
                st_d.out_en[g]    = frame[7];
            end
            if (wr_en[SEL_VDIV0 + g]) begin
                st_d.vdiv[g*CODE_W +: CODE_W] = frame[3 +: CODE_W];
                st_d.vref_ext[g]              = frame[7];
            end
        end
        if (wr_en[SEL_BRIDGE]) begin
            st_d.pwm_sel    = frame[3];
            st_d.decay_fast = frame[4];
            st_d.pwm_alloc  = frame[6:5];
        end
        if (wr_en[SEL_POL]) begin
            if (frame[3]) st_d.pol[NIB_W +: NIB_W] = frame[4 +: NIB_W];
            else          st_d.pol[0 +: NIB_W]     = frame[4 +: NIB_W];
        end
        if (wr_en[SEL_MISC]) begin
            st_d.sensor = frame[3];
            st_d.hyst   = frame[4 +: HYST_N];
        end
        if (wr_en[SEL_CUR]) begin
            if (frame[7]) st_d.cur[CODE_W +: CODE_W] = frame[3 +: CODE_W];
            else          st_d.cur[0 +: CODE_W]      = frame[3 +: CODE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cfg = st_q;

    // R2: one register per commit
    a_r2_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en));

    // R8: divisor fields move only after a divisor commit
    a_r8_vdiv_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en[SEL_VDIV0] || wr_en[SEL_VDIV0 + 1]) |=> $stable(st_q.vdiv));

    for (genvar g = 0; g < STEP_GRP; g++) begin : g_grp_chk
        // R5: applied direction/mode change only on this group's step edge
        a_r5_dir_waits_step: assert property (@(posedge clk) disable iff (rst)
            !step_rise[g] |=> $stable(st_q.dir[g]));
        a_r5_mode_waits_step: assert property (@(posedge clk) disable iff (rst)
            !step_rise[g] |=> $stable(st_q.mode[g]));
    end
endmodule

// File: rtl/ser_cfg_if.sv
module ser_cfg_if
    import cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ser_clk,
    input  logic       ser_dat,
    input  logic       ser_stb,
    input  logic [1:0] step_clk,
    output logic [1:0] step_dir,
    output logic [1:0] step_mode,
    output logic [1:0] step_hold,
    output logic [1:0] step_cnt_clr,
    output logic [1:0] step_out_en,
    output logic       pwm_sel,
    output logic       decay_fast,
    output logic [1:0] pwm_alloc,
    output logic [7:0] bridge_pol,
    output logic [7:0] vdiv_code,
    output logic [1:0] vref_ext,
    output logic [7:0] cur_code,
    output logic       sensor_on,
    output logic [2:0] hyst_en
);
    localparam int SER_W = 3;

    logic [SER_W-1:0]    ser_s;
    logic [STEP_GRP-1:0] step_s;
    logic [STEP_GRP-1:0] step_prev_d, step_prev_q;
    logic [STEP_GRP-1:0] step_rise;
    logic [FRAME_W-1:0]  frame;
    logic                commit;
    cfg_state_t          cfg;

    cfg_sync #(.W(SER_W), .STAGES(SYNC_STAGES)) u_ser_sync (
        .clk (clk),
        .rst (rst),
        .din ({ser_stb, ser_dat, ser_clk}),
        .dout(ser_s)
    );

    cfg_sync #(.W(STEP_GRP), .STAGES(SYNC_STAGES)) u_step_sync (
        .clk (clk),
        .rst (rst),
        .din (step_clk),
        .dout(step_s)
    );

    always_comb begin
        step_prev_d = step_s;
        step_rise   = step_s & ~step_prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) step_prev_q <= '0;
        else     step_prev_q <= step_prev_d;
    end

    cfg_shift u_shift (
        .clk   (clk),
        .rst   (rst),
        .sclk_s(ser_s[0]),
        .sdat_s(ser_s[1]),
        .stb_s (ser_s[2]),
        .frame (frame),
        .commit(commit)
    );

    cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .frame    (frame),
        .step_rise(step_rise),
        .cfg      (cfg)
    );

    assign step_dir     = cfg.dir;
    assign step_mode    = cfg.mode;
    assign step_hold    = cfg.hold;
    assign step_cnt_clr = cfg.cnt_clr;
    assign step_out_en  = cfg.out_en;
    assign pwm_sel      = cfg.pwm_sel;
    assign decay_fast   = cfg.decay_fast;
    assign pwm_alloc    = cfg.pwm_alloc;
    assign bridge_pol   = cfg.pol;
    assign vdiv_code    = cfg.vdiv;
    assign vref_ext     = cfg.vref_ext;
    assign cur_code     = cfg.cur;
    assign sensor_on    = cfg.sensor;
    assign hyst_en      = cfg.hyst;
endmodule

// File: tb/tb_ser_cfg_if.sv
module tb_ser_cfg_if;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_stb = 1'b0;
    logic [1:0] step_clk = 2'b00;
    logic [1:0] step_dir, step_mode, step_hold, step_cnt_clr, step_out_en;
    logic       pwm_sel, decay_fast, sensor_on;
    logic [1:0] pwm_alloc, vref_ext;
    logic [7:0] bridge_pol, vdiv_code, cur_code;
    logic [2:0] hyst_en;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    ser_cfg_if dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_stb(ser_stb),
        .step_clk(step_clk), .step_dir(step_dir), .step_mode(step_mode),
        .step_hold(step_hold), .step_cnt_clr(step_cnt_clr), .step_out_en(step_out_en),
        .pwm_sel(pwm_sel), .decay_fast(decay_fast), .pwm_alloc(pwm_alloc),
        .bridge_pol(bridge_pol), .vdiv_code(vdiv_code), .vref_ext(vref_ext),
        .cur_code(cur_code), .sensor_on(sensor_on), .hyst_en(hyst_en)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Entry: {send, frame[7:0], view[3:0], expected[7:0]}
    localparam int NV = 13;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 8'hD5, 4'd0, 8'h0A},   // R8 group 0 divisor
        {1'b0, 8'h00, 4'd1, 8'h01},   // R8 group 0 external ref
        {1'b1, 8'h1E, 4'd0, 8'h3A},   // R8 group 1 divisor
        {1'b1, 8'h7F, 4'd2, 8'h0F},   // R9 channel 0
        {1'b1, 8'hAF, 4'd2, 8'h5F},   // R9 channel 1
        {1'b1, 8'hDC, 4'd3, 8'h0B},   // R10 D7 ignored
        {1'b1, 8'h4A, 4'd4, 8'h09},   // R6 bridge mode
        {1'b1, 8'hA3, 4'd5, 8'h0A},   // R7 pair 0
        {1'b1, 8'h3B, 4'd5, 8'h3A},   // R7 pair 1
        {1'b1, 8'hB8, 4'd6, 8'h05},   // R4 group 0 immediate
        {1'b0, 8'h00, 4'd7, 8'h00},   // R5 still staged
        {1'b1, 8'h41, 4'd8, 8'h02},   // R4 group 1 immediate
        {1'b0, 8'h00, 4'd0, 8'h3A}    // R2 other registers untouched
    };

    function automatic logic [7:0] view(input logic [3:0] id);
        case (id)
            4'd0: view = vdiv_code;
            4'd1: view = {6'd0, vref_ext};
            4'd2: view = cur_code;
            4'd3: view = {4'd0, hyst_en, sensor_on};
            4'd4: view = {4'd0, pwm_alloc, decay_fast, pwm_sel};
            4'd5: view = bridge_pol;
            4'd6: view = {5'd0, step_out_en[0], step_cnt_clr[0], step_hold[0]};
            4'd7: view = {4'd0, step_mode, step_dir};
            4'd8: view = {5'd0, step_out_en[1], step_cnt_clr[1], step_hold[1]};
            default: view = 8'hEE;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] id);
        case (id)
            4'd0, 4'd1: req_of = "R8";
            4'd2:       req_of = "R9";
            4'd3:       req_of = "R10";
            4'd4:       req_of = "R6";
            4'd5:       req_of = "R7";
            4'd6, 4'd8: req_of = "R4";
            default:    req_of = "R5";
        endcase
    endfunction

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin   // R1: D0 first
            ser_dat = b[i];
            tick(3);
            ser_clk = 1'b1;
            tick(3);
            ser_clk = 1'b0;
            tick(3);
        end
    endtask

    task automatic strobe();
        ser_stb = 1'b1;
        tick(5);
        ser_stb = 1'b0;
        tick(4);
    endtask

    task automatic send(input logic [7:0] b);
        shift_bits(b);
        strobe();
    endtask

    task automatic step_pulse(input int g);
        step_clk[g] = 1'b1;
        tick(4);
        step_clk[g] = 1'b0;
        tick(4);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(2);
        // R11 reset state
        check("R11", {step_dir, step_mode, step_hold, step_cnt_clr, step_out_en, pwm_sel,
                      decay_fast, pwm_alloc, bridge_pol, vdiv_code, vref_ext, cur_code,
                      sensor_on, hyst_en}, 32'd0);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k][20]) send(VEC[k][19:12]);
            check(req_of(VEC[k][11:8]), {24'd0, view(VEC[k][11:8])}, {24'd0, VEC[k][7:0]});
        end

        // R5: other group's step clock leaves group 0 staged
        step_pulse(1);
        check("R5", {28'd0, step_mode, step_dir}, 32'h0);
        step_pulse(0);
        check("R5", {28'd0, step_mode, step_dir}, 32'h5);

        // R5: a later word replaces staged values
        send(8'h90);
        send(8'h88);
        check("R5", {28'd0, step_mode, step_dir}, 32'h5);
        step_pulse(0);
        check("R5", {28'd0, step_mode, step_dir}, 32'h1);

        // R3: bits clocked while strobe high are dropped
        send(8'h0D);
        check("R3", {24'd0, vdiv_code}, 32'h31);
        ser_stb = 1'b1;
        tick(3);
        shift_bits(8'hD5);
        ser_stb = 1'b0;
        tick(4);
        strobe();
        check("R3", {24'd0, vdiv_code}, 32'h31);

        // R2: commit latency of three system clock edges
        shift_bits(8'h17);
        ser_stb = 1'b1;
        tick(2);
        check("R2", {24'd0, cur_code}, 32'h5F);
        tick(1);
        check("R2", {24'd0, cur_code}, 32'h52);
        tick(3);
        ser_stb = 1'b0;
        tick(4);

        // R11: reset clears staged fields too
        send(8'hB8);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(2);
        check("R11", {step_dir, step_mode, step_hold, step_cnt_clr, step_out_en, pwm_sel,
                      decay_fast, pwm_alloc, bridge_pol, vdiv_code, vref_ext, cur_code,
                      sensor_on, hyst_en}, 32'd0);
        step_pulse(0);
        check("R11", {28'd0, step_mode, step_dir}, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule